// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block keeps an 8-bit up-counter that advances on cycles where a prescaler strobe is high. It watches one external capture pin and latches the counter into one of two capture registers: one for rising edges and one for falling edges. The host cannot read or write the counter. The host sees the counter only through the captured values, which it reads over a one-bit-select read port.

The pin goes through a two-stage synchroniser. It can then be inverted by a control bit before edge detection. Because the edge detector looks at the level after the inversion, toggling the inversion bit is itself seen as an edge and causes a capture.

Each capture can set a shared request flag when the flag-enable control is 1. The flag drives the interrupt output when the interrupt-enable control is 1. The flag holds until the host clears it. A capture in the same cycle as the clear takes priority.

Top module: `dcap_timer`

## Requirements
- R1: The hidden counter resets to 0x00. It adds one on each clock where `cnt_en` is 1, holds its value otherwise, and wraps from 0xFF to 0x00.
- R2: A falling edge of the effective level (synchronised pin XOR `cfg_invert`) loads the falling capture register with the counter value of the cycle in which the edge is detected. After a pin change, that is the value held just before the third rising clock edge.
- R3: A rising edge of the effective level loads the rising capture register in the same way as R2.
- R4: After reset, both capture registers read 0x00, and `irq_flag` and `irq` are 0.
- R5: `rd_data` shows the rising capture register when `rd_sel`=0 and the falling capture register when `rd_sel`=1.
- R6: A capture sets `irq_flag` when `cfg_flag_en` is 1. When `cfg_flag_en` is 0, a capture leaves the flag unchanged.
- R7: `irq` is 1 exactly when `irq_flag` is 1 and `cfg_irq_en` is 1.
- R8: `irq_flag` stays set until a clock with `flag_clr`=1 clears it. If a flag-setting capture occurs on the same clock as the clear, the flag stays 1.
- R9: Toggling `cfg_invert` while the pin is steady causes a capture on the next clock edge. The capture goes into the register that matches the direction of the change in effective level.
- R10: Each edge causes exactly one capture. While the effective level is steady, neither capture register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Count-enable strobe from a prescaler |
| cap_in | input | 1 | Asynchronous capture pin |
| cfg_invert | input | 1 | Inverts the synchronised pin before edge detection |
| cfg_flag_en | input | 1 | Allows captures to set the request flag |
| cfg_irq_en | input | 1 | Allows the request flag to drive `irq` |
| flag_clr | input | 1 | Clears the request flag on this clock |
| rd_sel | input | 1 | 0 selects the rising capture register, 1 selects the falling capture register |
| rd_data | output | 8 | Selected capture register |
| irq_flag | output | 1 | Capture request flag |
| irq | output | 1 | Interrupt output |

## Verification
The bench tracks the count independently and compares the captured values against it, with the exact synchroniser latency. A design off by one stage would capture a neighbouring count. A capture aimed at the counter's wrap shows whether the counter rolls from 0xFF to 0x00 or saturates.

Flipping the inversion bit with the pin held steady checks the spurious capture. That capture lands one clock after the toggle, not three. A design that ignored the inversion, or applied it after edge detection, would capture nothing.

Holding the pin steady after an edge shows whether a level-sensitive design keeps reloading a register. A clear issued on the same clock as a capture shows whether the clear wrongly wins over the set.

// File: rtl/dcap_pkg.sv
`timescale 1ns/1ps
package dcap_pkg;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned SYNC_DEF   = 2;
  localparam int unsigned N_EDGE     = 2;
  // Index order in the capture bank is also the read-select encoding
  localparam int unsigned EDGE_RISE  = 0;
  localparam int unsigned EDGE_FALL  = 1;
endpackage

// File: rtl/dcap_rst_sync.sv
`timescale 1ns/1ps
module dcap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dcap_edge_det.sv
`timescale 1ns/1ps
module dcap_edge_det #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  output logic rise,
  output logic fall
);
  logic [SYNC-1:0] sync_q;
  logic [SYNC-1:0] sync_d;
  logic            lvl;
  logic            prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC-2:0], pin};
    // Inversion applied before the compare: toggling it looks like an edge
    lvl    = sync_q[SYNC-1] ^ invert;
    rise   = lvl & ~prev_q;
    fall   = ~lvl & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
    end
  end
endmodule

// File: rtl/dcap_counter.sv
`timescale 1ns/1ps
module dcap_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/dcap_flag.sv
`timescale 1ns/1ps
module dcap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/dcap_timer.sv
`timescale 1ns/1ps
module dcap_timer
  import dcap_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned SYNC  = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cap_in,
  input  logic             cfg_invert,
  input  logic             cfg_flag_en,
  input  logic             cfg_irq_en,
  input  logic             flag_clr,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_flag,
  output logic             irq
);
  logic               rst_sync_n;
  logic               rise_ev;
  logic               fall_ev;
  logic [N_EDGE-1:0]  ev;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cap_q [N_EDGE];
  logic [CNT_W-1:0]   cap_d [N_EDGE];
  logic               flag_set;

  dcap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n(rst_sync_n)
  );

  dcap_edge_det #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin(cap_in), .invert(cfg_invert),
    .rise(rise_ev), .fall(fall_ev)
  );

  dcap_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en(cnt_en), .cnt(cnt_q)
  );

  always_comb begin
    ev[EDGE_RISE] = rise_ev;
    ev[EDGE_FALL] = fall_ev;
  end

  for (genvar e = 0; e < N_EDGE; e++) begin : g_cap
    always_comb begin
      cap_d[e] = cap_q[e];
      if (ev[e]) cap_d[e] = cnt_q;
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) cap_q[e] <= '0;
      else             cap_q[e] <= cap_d[e];
    end
  end

  always_comb begin
    flag_set = (|ev) & cfg_flag_en;
    rd_data  = cap_q[rd_sel];
    irq      = irq_flag & cfg_irq_en;
  end

  dcap_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .set(flag_set), .clr(flag_clr), .flag(irq_flag)
  );
endmodule

// File: rtl/dcap_timer_chk.sv
`timescale 1ns/1ps
module dcap_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rise_ev,
  input logic             fall_ev,
  input logic [CNT_W-1:0] cap_rise,
  input logic [CNT_W-1:0] cap_fall,
  input logic             cfg_flag_en,
  input logic             cfg_irq_en,
  input logic             flag_clr,
  input logic             irq_flag,
  input logic             irq
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q)); // R1
  AST_FALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> cap_fall == $past(cnt_q)); // R2
  AST_RISE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> cap_rise == $past(cnt_q)); // R3
  AST_RISE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev |=> $stable(cap_rise)); // R10
  AST_FALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(cap_fall)); // R10
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev || fall_ev) && cfg_flag_en |=> irq_flag); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !((rise_ev || fall_ev) && cfg_flag_en) |=> !irq_flag); // R8
  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag && !((rise_ev || fall_ev) && cfg_flag_en) |=> !irq_flag); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_irq_en && irq_flag); // R7
endmodule

bind dcap_timer dcap_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .cnt_q(cnt_q),
  .rise_ev(rise_ev), .fall_ev(fall_ev),
  .cap_rise(cap_q[0]), .cap_fall(cap_q[1]),
  .cfg_flag_en(cfg_flag_en), .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr),
  .irq_flag(irq_flag), .irq(irq)
);

// File: tb/dcap_timer_tb_top.sv
`timescale 1ns/1ps
module dcap_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       cap_in = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       cfg_flag_en = 1'b0;
  logic       cfg_irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       irq_flag;
  logic       irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] ref_cnt = 8'h00;
  logic [7:0] exp_r = 8'h00;
  logic [7:0] exp_f = 8'h00;

  always #4 clk = ~clk;

  always @(posedge clk) if (cnt_en) ref_cnt <= ref_cnt + 8'h01;

  dcap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
    .cfg_invert(cfg_invert), .cfg_flag_en(cfg_flag_en), .cfg_irq_en(cfg_irq_en),
    .flag_clr(flag_clr), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_flag(irq_flag), .irq(irq)
  );

  typedef struct packed {
    logic pin; logic inv; logic fe; logic ie;
    logic er;  logic ef;  logic efl;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_both(input string req, output logic [7:0] r, output logic [7:0] f);
    rd_sel = 1'b0; #1; r = rd_data;
    rd_sel = 1'b1; #1; f = rd_data;
    rd_sel = 1'b0;
    if (req.len() == 0) r = r;
  endtask

  task automatic check_caps(input string req);
    logic [7:0] r, f;
    read_both(req, r, f);
    chk({req, " rising capture"}, {24'h0, r}, {24'h0, exp_r});
    chk({req, " falling capture"}, {24'h0, f}, {24'h0, exp_f});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] c0, c2;
    logic       last_inv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4, R5: reset state
    check_caps("R4 R5 reset");
    chk("R4 flag after reset", {31'h0, irq_flag}, 32'h0);
    chk("R4 irq after reset", {31'h0, irq}, 32'h0);
    cnt_en = 1'b1;
    repeat (5) @(negedge clk);

    last_inv = 1'b0;
    for (int i = 0; i < 8; i++) begin
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      cap_in = VEC[i].pin; cfg_invert = VEC[i].inv;
      cfg_flag_en = VEC[i].fe; cfg_irq_en = VEC[i].ie;
      c0 = ref_cnt;
      @(negedge clk);
      @(negedge clk);
      c2 = ref_cnt;
      @(negedge clk);
      if (VEC[i].er) exp_r = (VEC[i].inv != last_inv) ? c0 : c2;
      if (VEC[i].ef) exp_f = (VEC[i].inv != last_inv) ? c0 : c2;
      last_inv = VEC[i].inv;
      // R2 R3 captures, R9 inversion toggles, R6 flag gating, R7 irq gating
      check_caps($sformatf("R2 R3 R9 vec%0d", i));
      chk($sformatf("R6 flag vec%0d", i), {31'h0, irq_flag}, {31'h0, VEC[i].efl});
      chk($sformatf("R7 irq vec%0d", i), {31'h0, irq}, {31'h0, VEC[i].efl & VEC[i].ie});
    end

    // R8: plain clear
    cfg_irq_en = 1'b1;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R8 clear", {31'h0, irq_flag}, 32'h0);
    chk("R7 irq after clear", {31'h0, irq}, 32'h0);
    // R8: clear on the same clock as a flag-setting capture
    cap_in = 1'b0;
    @(negedge clk);
    c2 = ref_cnt;
    @(negedge clk);
    c2 = ref_cnt;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_f = c2;
    chk("R8 capture beats clear", {31'h0, irq_flag}, 32'h1);
    check_caps("R8 R2 fall with clear");
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R8 clear after", {31'h0, irq_flag}, 32'h0);

    // R1: counter held while strobe low
    cnt_en = 1'b0;
    @(negedge clk);
    cap_in = 1'b1;
    c0 = ref_cnt;
    repeat (3) @(negedge clk);
    exp_r = c0;
    check_caps("R1 hold R3");
    // R10: steady level, counter running, no further capture
    cnt_en = 1'b1;
    repeat (12) @(negedge clk);
    check_caps("R10 steady");

    // R1: wrap from 0xFF to 0x00 seen through a capture
    while (ref_cnt != 8'hFE) @(negedge clk);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
    exp_f = 8'h00;
    check_caps("R1 wrap R2");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule